// File: doc/BRIEF.md
# Mailbox Threshold Interrupt Controller

This block holds the interrupt logic for one side of a two-processor mailbox. It watches the fill level of the outgoing (send) queue and of the incoming (receive) queue. Each level is compared with a threshold that software programs. The send side is flagged when its queue has drained to the threshold or below. The receive side is flagged when its queue holds more words than its threshold. A rising edge on either flag latches an interrupt status bit. Any raised bit of the mailbox error flags latches a third status bit.

Software reaches five registers through a small register port. Writes take effect at the clock edge, and reads are combinational from the address. Each status bit can be masked. The masked, or pending, view is readable, and the OR of the pending bits drives a single interrupt line. The queues and the bus protocol sit outside this block.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: After reset, the send threshold (byte address 0x18), receive threshold (0x1C), status (0x20), enable (0x24) and pending (0x28) registers all read 0, and `irq` is 0. Every other address reads 0.
- R2: Each threshold register stores only the low log2(DEPTH) bits of the written word and reads back zero above them. Writes to the pending register have no effect.
- R3: `send_active` is 1 exactly when the send level presented before the previous clock edge was less than or equal to the send threshold then held.
- R4: `recv_active` is 1 exactly when the receive level presented before the previous clock edge was strictly greater than the receive threshold then held.
- R5: Status bit 0 (send event) becomes 1 at the same edge where `send_active` rises. A falling edge sets nothing, and the first evaluation after reset is never treated as a rising edge.
- R6: Status bit 1 (receive event) becomes 1 at the same edge where `recv_active` rises.
- R7: Status bit 2 (error event) becomes 1 at the edge after any bit of `err_flags` is high.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a set event and a clear hit the same bit at the same edge, the bit stays 1.
- R9: Reprogramming a threshold alone produces a rising edge and an event. A threshold written at edge E changes the flag, and sets the status bit, at edge E+1.
- R10: The pending register reads status AND enable, bit for bit. `irq` is the OR of the pending bits, so it stays 0 while the enable register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| send_level | input | LVL_W | Words held in the send queue (0..DEPTH) |
| recv_level | input | LVL_W | Words held in the receive queue (0..DEPTH) |
| err_flags | input | ERR_W | Mailbox error flags; any high bit raises the error event |
| reg_wr_en | input | 1 | Write strobe for one cycle |
| reg_wr_addr | input | ADDR_W | Byte address of the write |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_addr | input | ADDR_W | Byte address of the read |
| reg_rd_data | output | DATA_W | Read data, combinational from reg_rd_addr |
| send_active | output | 1 | Registered send-threshold flag |
| recv_active | output | 1 | Registered receive-threshold flag |
| irq | output | 1 | Interrupt line, OR of the pending bits |

## Verification
A level change driven before an edge moves its active flag and any status bit at that same edge. An error flag sets its status bit at that edge too. A threshold write needs one more edge, because the stored threshold is updated first and compared afterwards. Register writes are visible on the combinational read port right after their edge. The bench drives every stimulus just after a rising edge. It queues the expected read value and flag state. The monitor compares them at the following falling edge, so each sample falls at the cycle its result is due. The threshold-write case deliberately checks the intermediate cycle, where the status bit must still be clear.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
    // Register byte offsets
    localparam int unsigned OFS_SEND_THR = 'h18;
    localparam int unsigned OFS_RECV_THR = 'h1C;
    localparam int unsigned OFS_STAT     = 'h20;
    localparam int unsigned OFS_MASK     = 'h24;
    localparam int unsigned OFS_PEND     = 'h28;
    // Event bit positions shared by status, enable and pending
    localparam int unsigned EV_SEND = 0;
    localparam int unsigned EV_RECV = 1;
    localparam int unsigned EV_ERR  = 2;
    localparam int unsigned EV_NUM  = 3;
endpackage

// File: rtl/mbox_thr_flag.sv
module mbox_thr_flag #(
    parameter int LVL_W        = 5,
    parameter int THR_W        = 4,
    parameter bit AT_OR_BELOW  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [THR_W-1:0] thr,
    output logic             active,
    output logic             rise,
    output logic             primed
);
    typedef struct packed {
        logic act;
        logic primed;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic [LVL_W-1:0] thr_ext;
    logic cmp;

    assign thr_ext = LVL_W'(thr);

    generate
        if (AT_OR_BELOW) begin : g_low
            assign cmp = (level <= thr_ext);
        end else begin : g_high
            assign cmp = (level > thr_ext);
        end
    endgenerate

    always_comb begin
        st_d.act    = cmp;
        st_d.primed = 1'b1;
        // edge only once a prior evaluation exists
        rise        = cmp & ~st_q.act & st_q.primed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.act;
    assign primed = st_q.primed;
endmodule

// File: rtl/mbox_irq_status.sv
module mbox_irq_status #(
    parameter int NUM_EV = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] set_ev,
    input  logic [NUM_EV-1:0] clr_req,
    input  logic              mask_we,
    input  logic [NUM_EV-1:0] mask_wdata,
    output logic [NUM_EV-1:0] stat,
    output logic [NUM_EV-1:0] mask,
    output logic [NUM_EV-1:0] pend
);
    typedef struct packed {
        logic [NUM_EV-1:0] stat;
        logic [NUM_EV-1:0] mask;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a set event overrides a simultaneous clear
        st_d.stat = (st_q.stat & ~clr_req) | set_ev;
        if (mask_we) st_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;
    assign mask = st_q.mask;
    assign pend = st_q.stat & st_q.mask;
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
    import mbox_irq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int ERR_W  = 2,
    localparam int THR_W = $clog2(DEPTH),
    localparam int LVL_W = THR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  send_level,
    input  logic [LVL_W-1:0]  recv_level,
    input  logic [ERR_W-1:0]  err_flags,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [ADDR_W-1:0] reg_rd_addr,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic              send_active,
    output logic              recv_active,
    output logic              irq
);
    typedef struct packed {
        logic [THR_W-1:0] sit;
        logic [THR_W-1:0] rit;
    } thr_st_t;

    thr_st_t cfg_d, cfg_q;

    logic [THR_W-1:0]  sit_q, rit_q;
    logic              send_rise, recv_rise, send_primed, recv_primed;
    logic [EV_NUM-1:0] set_ev, clr_req, is_q, ie_q, ip_q;
    logic              wr_stat, wr_mask;

    assign sit_q = cfg_q.sit;
    assign rit_q = cfg_q.rit;

    // Write decode and threshold registers
    always_comb begin
        cfg_d   = cfg_q;
        wr_stat = reg_wr_en && (reg_wr_addr == ADDR_W'(OFS_STAT));
        wr_mask = reg_wr_en && (reg_wr_addr == ADDR_W'(OFS_MASK));
        if (reg_wr_en && reg_wr_addr == ADDR_W'(OFS_SEND_THR))
            cfg_d.sit = reg_wr_data[THR_W-1:0];
        if (reg_wr_en && reg_wr_addr == ADDR_W'(OFS_RECV_THR))
            cfg_d.rit = reg_wr_data[THR_W-1:0];
        clr_req = wr_stat ? reg_wr_data[EV_NUM-1:0] : '0;
        set_ev          = '0;
        set_ev[EV_SEND] = send_rise;
        set_ev[EV_RECV] = recv_rise;
        set_ev[EV_ERR]  = |err_flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    mbox_thr_flag #(.LVL_W(LVL_W), .THR_W(THR_W), .AT_OR_BELOW(1'b1)) u_send (
        .clk(clk), .rst_n(rst_n), .level(send_level), .thr(cfg_q.sit),
        .active(send_active), .rise(send_rise), .primed(send_primed)
    );

    mbox_thr_flag #(.LVL_W(LVL_W), .THR_W(THR_W), .AT_OR_BELOW(1'b0)) u_recv (
        .clk(clk), .rst_n(rst_n), .level(recv_level), .thr(cfg_q.rit),
        .active(recv_active), .rise(recv_rise), .primed(recv_primed)
    );

    mbox_irq_status #(.NUM_EV(EV_NUM)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_req(clr_req),
        .mask_we(wr_mask), .mask_wdata(reg_wr_data[EV_NUM-1:0]),
        .stat(is_q), .mask(ie_q), .pend(ip_q)
    );

    assign irq = |ip_q;

    // Read mux
    always_comb begin
        reg_rd_data = '0;
        case (reg_rd_addr)
            ADDR_W'(OFS_SEND_THR): reg_rd_data = DATA_W'(cfg_q.sit);
            ADDR_W'(OFS_RECV_THR): reg_rd_data = DATA_W'(cfg_q.rit);
            ADDR_W'(OFS_STAT):     reg_rd_data = DATA_W'(is_q);
            ADDR_W'(OFS_MASK):     reg_rd_data = DATA_W'(ie_q);
            ADDR_W'(OFS_PEND):     reg_rd_data = DATA_W'(ip_q);
            default:               reg_rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk
    import mbox_irq_pkg::*;
#(
    parameter int LVL_W = 5,
    parameter int THR_W = 4,
    parameter int ERR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  send_level,
    input logic [LVL_W-1:0]  recv_level,
    input logic [THR_W-1:0]  sit_q,
    input logic [THR_W-1:0]  rit_q,
    input logic [ERR_W-1:0]  err_flags,
    input logic              send_active,
    input logic              recv_active,
    input logic [EV_NUM-1:0] is_q,
    input logic [EV_NUM-1:0] ie_q,
    input logic              send_primed,
    input logic              recv_primed,
    input logic              irq
);
    a_r3_send_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (send_active == ($past(send_level) <= {1'b0, $past(sit_q)})));

    a_r4_recv_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (recv_active == ($past(recv_level) > {1'b0, $past(rit_q)})));

    a_r5_send_event: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(send_active) && $past(send_primed)) |-> is_q[EV_SEND]);

    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_q[EV_SEND]) |-> $rose(send_active));

    a_r6_recv_event: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(recv_active) && $past(recv_primed)) |-> is_q[EV_RECV]);

    a_r7_err_event: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_flags) |=> is_q[EV_ERR]);

    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == '0) |-> !irq);
endmodule

bind mbox_irq_ctrl mbox_irq_chk #(.LVL_W(LVL_W), .THR_W(THR_W), .ERR_W(ERR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .send_level(send_level), .recv_level(recv_level),
    .sit_q(sit_q), .rit_q(rit_q), .err_flags(err_flags),
    .send_active(send_active), .recv_active(recv_active),
    .is_q(is_q), .ie_q(ie_q), .send_primed(send_primed),
    .recv_primed(recv_primed), .irq(irq)
);

// File: tb/mbox_irq_ctrl_tb.sv
`timescale 1ns/100ps
module mbox_irq_ctrl_tb;
    localparam logic [5:0] A_SIT = 6'h18, A_RIT = 6'h1C, A_IS = 6'h20,
                           A_IE = 6'h24, A_IP = 6'h28, A_NONE = 6'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  send_level = '0, recv_level = '0;
    logic [1:0]  err_flags = '0;
    logic        reg_wr_en = 1'b0;
    logic [5:0]  reg_wr_addr = '0, reg_rd_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        send_active, recv_active, irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mbox_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .send_level(send_level), .recv_level(recv_level),
        .err_flags(err_flags), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .send_active(send_active), .recv_active(recv_active), .irq(irq)
    );

    typedef struct {
        logic [5:0]  addr;
        logic [31:0] exp;
        logic [2:0]  flg;   // {irq, send_active, recv_active}
        string       tag;
    } exp_t;

    exp_t sb[$];

    // Monitor: pops one expectation per falling edge
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (reg_rd_data !== e.exp || {irq, send_active, recv_active} !== e.flg) begin
                bad++;
                $display("FAIL %s: addr=%h data=%h flags=%b expected data=%h flags=%b",
                         e.tag, e.addr, reg_rd_data, {irq, send_active, recv_active},
                         e.exp, e.flg);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic lv(input logic [4:0] s, input logic [4:0] r);
        send_level = s; recv_level = r;
        tick();
    endtask

    task automatic chk(input logic [5:0] a, input logic [31:0] e,
                       input logic [2:0] f, input string t);
        exp_t it;
        reg_rd_addr = a;
        it.addr = a; it.exp = e; it.flg = f; it.tag = t;
        sb.push_back(it);
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(200_000.0);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick(); tick();
        // R1 reset state; R5 no event on the first evaluation (send flag already 1)
        chk(A_SIT, 0, 3'b010, "R1 send thr");
        chk(A_RIT, 0, 3'b010, "R1 recv thr");
        chk(A_IS,  0, 3'b010, "R1/R5 status");
        chk(A_IE,  0, 3'b010, "R1 enable");
        chk(A_IP,  0, 3'b010, "R1 pending");
        chk(A_NONE, 0, 3'b010, "R1 unmapped");
        // R2 truncation and ignored pending write
        wr(A_SIT, 32'h35);
        chk(A_SIT, 32'h5, 3'b010, "R2 send thr truncate");
        wr(A_RIT, 32'hFFF3);
        chk(A_RIT, 32'h3, 3'b010, "R2 recv thr truncate");
        wr(A_IP, 32'h7);
        chk(A_IP, 0, 3'b010, "R2 pending write ignored");
        // R3 send flag, falling edge sets nothing; R5 rising edge
        lv(5'd6, 5'd0);
        chk(A_IS, 0, 3'b000, "R3/R5 falling send");
        lv(5'd5, 5'd0);
        chk(A_IS, 32'h1, 3'b010, "R3/R5 send at threshold");
        // R4 and R6
        lv(5'd5, 5'd3);
        chk(A_IS, 32'h1, 3'b010, "R4 recv equal threshold");
        lv(5'd5, 5'd4);
        chk(A_IS, 32'h3, 3'b011, "R4/R6 recv above threshold");
        // R8 write-one-to-clear
        wr(A_IS, 32'h1);
        chk(A_IS, 32'h2, 3'b011, "R8 clear bit0");
        wr(A_IS, 32'h0);
        chk(A_IS, 32'h2, 3'b011, "R8 zero write");
        wr(A_IS, 32'h2);
        chk(A_IS, 0, 3'b011, "R8 clear bit1");
        // R10 mask and pending
        wr(A_IE, 32'h3);
        chk(A_IE, 32'h3, 3'b011, "R10 enable readback");
        chk(A_IP, 0, 3'b011, "R10 nothing pending");
        lv(5'd6, 5'd4);
        lv(5'd0, 5'd4);
        chk(A_IP, 32'h1, 3'b111, "R10 pending send");
        wr(A_IS, 32'h7);
        chk(A_IS, 0, 3'b011, "R8 clear all");
        // R9 threshold reprogramming
        wr(A_RIT, 32'hF);
        tick();
        chk(A_IS, 0, 3'b010, "R9 recv flag drops");
        wr(A_RIT, 32'h2);
        chk(A_IS, 0, 3'b010, "R9 one edge after write");
        tick();
        chk(A_IS, 32'h2, 3'b111, "R9 event from threshold write");
        chk(A_IP, 32'h2, 3'b111, "R9/R10 pending");
        wr(A_IS, 32'h7);
        chk(A_IS, 0, 3'b011, "R9 cleared");
        // R7 error event, masked then enabled
        err_flags = 2'b01;
        tick();
        err_flags = 2'b00;
        chk(A_IS, 32'h4, 3'b011, "R7 error event");
        chk(A_IP, 0, 3'b011, "R7/R10 error masked");
        wr(A_IE, 32'h7);
        chk(A_IP, 32'h4, 3'b111, "R7/R10 error pending");
        // R8 set wins over clear
        err_flags = 2'b10;
        wr(A_IS, 32'h4);
        err_flags = 2'b00;
        chk(A_IS, 32'h4, 3'b111, "R8 set beats clear");
        wr(A_IS, 32'h4);
        chk(A_IS, 0, 3'b011, "R8 clear after collision");
        tick();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule